// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block decides when a calendar alarm goes off. It holds four alarm fields: minute, hour, day of month and weekday. Each field is kept in BCD and has an exclude bit of its own. Once per minute, at the seconds strobe that brings the seconds count to 00, it compares every included field with the current time. When all of them agree, it sets a sticky alarm flag. The time counters live elsewhere. They supply the current seconds, minute, hour (always in 24-hour BCD), day and weekday, together with a strobe that pulses each time the seconds value changes.

Software sets the block up through a small write port. The port has four alarm registers and a control register. The control register holds the interrupt enable and the hour format, and it also clears the flag. In 12-hour format the alarm hour is written as 1 to 12 with an afternoon bit, and the block converts it before comparing. The interrupt output models an open-drain, active-low request. It is pulled low while the flag is set and the interrupt is enabled, and it is released otherwise.

Top module: `cal_alarm_top`

## Requirements
- R1: The alarm registers sit at write addresses 0 (minute, BCD 00-59), 1 (hour), 2 (day, BCD 01-31) and 3 (weekday, 0-6). In each, bit 7 = 1 excludes the field from matching. After reset every field is excluded, the flag is 0, irq_n is 1, the interrupt is disabled and the hour format is 24-hour.
- R2: Comparison happens only in a cycle where sec_tick is 1 and cur_sec is 00. A strobe with any other seconds value, or a seconds value of 00 without a strobe, never sets the flag.
- R3: An included minute, day or weekday field matches when its BCD value equals cur_min, cur_day or cur_wday.
- R4: In 24-hour format (control bit 2 = 0), an included hour field matches when its bits 5:0, BCD 00-23, equal cur_hour.
- R5: In 12-hour format (control bit 2 = 1), alarm hour bit 5 marks the afternoon and bits 4:0 hold BCD 01-12. 12 morning stands for hour 00, 12 afternoon for hour 12, and any other afternoon hour for that hour plus 12. This is compared against cur_hour, which is always in 24-hour BCD.
- R6: The flag sets only when every included field matches. Excluded fields are ignored. When all four fields are excluded, the flag never sets.
- R7: The flag is sticky. A write to address 4 with bit 1 = 0 clears it. A write to address 4 with bit 1 = 1 neither sets it nor clears it.
- R8: If a flag-clearing write and a setting comparison fall in the same cycle, the flag ends up set.
- R9: irq_n is 0 exactly while the flag is set and the interrupt enable (address 4, bit 0) is 1. Clearing either the flag or the enable releases it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| sec_tick | input | 1 | Pulses for one cycle when the seconds value changes |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, 24-hour BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday, 0-6 |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt request; 0 = pull line low, 1 = released |

## Verification
The assertions watch the following on every cycle:
- the flag rises only after a seconds-00 strobe with a hit;
- the flag holds until a clearing write arrives;
- a set wins over a clear in the same cycle;
- the flag stays low when every field is excluded;
- the interrupt line follows the flag and the enable.

Only the bench's sweeps can show that the comparison itself is right: every pair of alarm and current value for each field, every 12-hour alarm against every 24-hour time, and all sixteen exclude masks crossed with every pattern of mismatching fields.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;
  localparam int NFIELD   = 4;
  localparam int REG_W    = 8;
  localparam int FLD_W    = REG_W - 1;
  localparam int EXCL_BIT = REG_W - 1;

  // field slots; the slot index is also the write address
  localparam int FI_MIN  = 0;
  localparam int FI_HOUR = 1;
  localparam int FI_DAY  = 2;
  localparam int FI_WDAY = 3;
  localparam int AD_CTRL = NFIELD;

  // control register bits
  localparam int CB_IRQEN = 0;
  localparam int CB_FLAG  = 1;
  localparam int CB_H12   = 2;

  function automatic logic [FLD_W-1:0] field_mask(input int idx);
    case (idx)
      FI_MIN:  return 7'h7F;
      FI_HOUR: return 7'h3F;
      FI_DAY:  return 7'h3F;
      default: return 7'h07;
    endcase
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [6:0] b);
    logic [6:0] tens;
    tens = {4'b0000, b[6:4]};
    return (tens << 3) + (tens << 1) + {3'b000, b[3:0]};
  endfunction

  // alarm hour register value -> hour 0..23 (out-of-range codes map above 23)
  function automatic logic [6:0] hour_to_24(input logic [5:0] a, input logic h12);
    logic [6:0] hb;
    if (!h12) begin
      hb = bcd_to_bin({1'b0, a});
    end else begin
      hb = bcd_to_bin({2'b00, a[4:0]});
      if (hb == 7'd12) hb = a[5] ? 7'd12 : 7'd0;
      else if (a[5])   hb = hb + 7'd12;
    end
    return hb;
  endfunction
endpackage

// File: rtl/alm_rst_sync.sv
`timescale 1ns/1ps
module alm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/alm_regs.sv
`timescale 1ns/1ps
module alm_regs
  import alm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [REG_W-1:0]               wr_data,
  output logic [NFIELD-1:0][REG_W-1:0]   alm_q,
  output logic                           irq_en_q,
  output logic                           h12_q,
  output logic                           flag_clr
);
  localparam logic [REG_W-1:0] ALM_RST = REG_W'(1) << EXCL_BIT;

  logic [NFIELD-1:0]             fld_we;
  logic [NFIELD-1:0][REG_W-1:0]  alm_d;
  logic                          ctrl_we;
  logic                          irq_en_d;
  logic                          h12_d;

  always_comb begin
    for (int i = 0; i < NFIELD; i++) begin
      fld_we[i] = wr_en && (wr_addr == ADDR_W'(i));
      alm_d[i]  = fld_we[i] ? wr_data : alm_q[i];
    end
    ctrl_we  = wr_en && (wr_addr == ADDR_W'(AD_CTRL));
    irq_en_d = ctrl_we ? wr_data[CB_IRQEN] : irq_en_q;
    h12_d    = ctrl_we ? wr_data[CB_H12]   : h12_q;
    flag_clr = ctrl_we && !wr_data[CB_FLAG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q    <= {NFIELD{ALM_RST}};
      irq_en_q <= 1'b0;
      h12_q    <= 1'b0;
    end else begin
      for (int i = 0; i < NFIELD; i++) begin
        if (fld_we[i]) alm_q[i] <= alm_d[i];
      end
      if (ctrl_we) begin
        irq_en_q <= irq_en_d;
        h12_q    <= h12_d;
      end
    end
  end
endmodule

// File: rtl/alm_match.sv
`timescale 1ns/1ps
module alm_match
  import alm_pkg::*;
(
  input  logic [NFIELD-1:0][REG_W-1:0] alm_q,
  input  logic [NFIELD-1:0][FLD_W-1:0] cur,
  input  logic                         h12,
  output logic                         hit
);
  logic [NFIELD-1:0] incl;
  logic [NFIELD-1:0] eq;

  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_cmp
    assign incl[gi] = ~alm_q[gi][EXCL_BIT];
    if (gi == FI_HOUR) begin : g_hour
      assign eq[gi] = (hour_to_24(alm_q[gi][5:0], h12) ==
                       bcd_to_bin(cur[gi] & field_mask(gi)));
    end else begin : g_plain
      assign eq[gi] = ((alm_q[gi][FLD_W-1:0] & field_mask(gi)) ==
                       (cur[gi] & field_mask(gi)));
    end
  end

  always_comb hit = (|incl) && (&(eq | ~incl));
endmodule

// File: rtl/alm_flag.sv
`timescale 1ns/1ps
module alm_flag
  import alm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic [FLD_W-1:0] cur_sec,
  input  logic             hit,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic             flag_q,
  output logic             irq_n
);
  logic eval;
  logic set_ev;
  logic flag_d;

  always_comb begin
    eval   = sec_tick && (cur_sec == '0);
    set_ev = eval && hit;
    if (set_ev)        flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq_n = ~(flag_q & irq_en);

  // R2
  fl_eval_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval && !flag_q) |=> !flag_q);
  // R8
  fl_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && hit) |=> flag_q);
  // R7
  fl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  // R7
  fl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(eval && hit)) |=> !flag_q);
endmodule

// File: rtl/cal_alarm_top.sv
`timescale 1ns/1ps
module cal_alarm_top
  import alm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              sec_tick,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_day,
  input  logic [2:0]        cur_wday,
  output logic              alarm_flag,
  output logic              irq_n
);
  logic                         rst_s_n;
  logic [NFIELD-1:0][REG_W-1:0] alm_q;
  logic [NFIELD-1:0][FLD_W-1:0] cur_pk;
  logic                         irq_en;
  logic                         h12;
  logic                         flag_clr;
  logic                         hit;

  always_comb begin
    cur_pk[FI_MIN]  = cur_min;
    cur_pk[FI_HOUR] = {1'b0, cur_hour};
    cur_pk[FI_DAY]  = {1'b0, cur_day};
    cur_pk[FI_WDAY] = {4'b0000, cur_wday};
  end

  alm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  alm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alm_q(alm_q), .irq_en_q(irq_en), .h12_q(h12),
    .flag_clr(flag_clr)
  );

  alm_match u_match (
    .alm_q(alm_q), .cur(cur_pk), .h12(h12), .hit(hit)
  );

  alm_flag u_flag (
    .clk(clk), .rst_n(rst_s_n), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .hit(hit), .flag_clr(flag_clr), .irq_en(irq_en),
    .flag_q(alarm_flag), .irq_n(irq_n)
  );

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !alarm_flag |-> irq_n);
  // R9
  irq_drive_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (alarm_flag && irq_en) |-> !irq_n);
  // R6
  all_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (alm_q[0][EXCL_BIT] && alm_q[1][EXCL_BIT] && alm_q[2][EXCL_BIT] &&
     alm_q[3][EXCL_BIT] && !alarm_flag) |=> !alarm_flag);
endmodule

// File: tb/sim_cal_alarm_top.sv
`timescale 1ns/1ps
module sim_cal_alarm_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       sec_tick;
  logic [6:0] cur_sec;
  logic [6:0] cur_min;
  logic [5:0] cur_hour;
  logic [5:0] cur_day;
  logic [2:0] cur_wday;
  logic       alarm_flag;
  logic       irq_n;

  int  vecs = 0;
  int  errs = 0;
  bit  done = 0;
  logic [7:0] ctrl_base;

  always #10 clk = ~clk;

  cal_alarm_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .cur_wday(cur_wday), .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [7:0] enc12(input int h);
    int h12;
    logic [7:0] r;
    h12  = (h % 12 == 0) ? 12 : h % 12;
    r    = to_bcd(h12);
    r[5] = (h >= 12);
    return r;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input logic [6:0] s);
    sec_tick = 1'b1; cur_sec = s;
    @(negedge clk);
    sec_tick = 1'b0; cur_sec = 7'h01;
  endtask

  task automatic vec(input bit exp, input string tag);
    wr(4, ctrl_base);            // bit1 = 0: clear the flag first
    tick(7'h00);
    chk(alarm_flag, exp, tag);
    chk(irq_n, !(exp && ctrl_base[0]), tag);
  endtask

  task automatic set_cur(input int m, input int h, input int d, input int w);
    cur_min = to_bcd(m)[6:0]; cur_hour = to_bcd(h)[5:0];
    cur_day = to_bcd(d)[5:0]; cur_wday = 3'(w);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    sec_tick = 1'b0; cur_sec = 7'h01;
    set_cur(0, 0, 1, 0);
    ctrl_base = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(alarm_flag, 1'b0, "R1 flag after reset");
    chk(irq_n, 1'b1, "R1 irq_n after reset");
    // R1/R6: all fields excluded after reset -> a strobe at 00 sets nothing
    set_cur(0, 0, 0, 0);
    cur_day = 6'h00;
    tick(7'h00);
    chk(alarm_flag, 1'b0, "R1 excluded fields after reset");

    // R4 hour sweep, 24-hour format
    wr(0, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
    ctrl_base = 8'h01;
    for (int ah = 0; ah < 24; ah++) begin
      wr(1, to_bcd(ah));
      for (int ch = 0; ch < 24; ch++) begin
        cur_hour = to_bcd(ch)[5:0];
        vec(ah == ch, "R4 hour 24h");
      end
    end

    // R5 hour sweep, 12-hour format
    ctrl_base = 8'h05;
    for (int ah = 0; ah < 24; ah++) begin
      wr(1, enc12(ah));
      for (int ch = 0; ch < 24; ch++) begin
        cur_hour = to_bcd(ch)[5:0];
        vec(ah == ch, "R5 hour 12h");
      end
    end
    ctrl_base = 8'h01;
    wr(1, 8'h80);

    // R3 minute sweep
    for (int am = 0; am < 60; am++) begin
      wr(0, to_bcd(am));
      for (int cm = 0; cm < 60; cm++) begin
        cur_min = to_bcd(cm)[6:0];
        vec(am == cm, "R3 minute");
      end
    end
    wr(0, 8'h80);

    // R3 day sweep
    for (int ad = 1; ad < 32; ad++) begin
      wr(2, to_bcd(ad));
      for (int cd = 1; cd < 32; cd++) begin
        cur_day = to_bcd(cd)[5:0];
        vec(ad == cd, "R3 day");
      end
    end
    wr(2, 8'h80);

    // R3 weekday sweep
    for (int aw = 0; aw < 7; aw++) begin
      wr(3, 8'(aw));
      for (int cw = 0; cw < 7; cw++) begin
        cur_wday = 3'(cw);
        vec(aw == cw, "R3 weekday");
      end
    end

    // R6 exclude masks x mismatch patterns
    for (int mask = 0; mask < 16; mask++) begin
      wr(0, (mask[0] ? 8'h80 : 8'h00) | to_bcd(30));
      wr(1, (mask[1] ? 8'h80 : 8'h00) | to_bcd(10));
      wr(2, (mask[2] ? 8'h80 : 8'h00) | to_bcd(15));
      wr(3, (mask[3] ? 8'h80 : 8'h00) | 8'h03);
      for (int mm = 0; mm < 16; mm++) begin
        set_cur(mm[0] ? 31 : 30, mm[1] ? 11 : 10, mm[2] ? 16 : 15, mm[3] ? 4 : 3);
        vec((mask != 15) && ((mm & ~mask & 15) == 0), "R6 mask");
      end
    end

    // full match configuration for the remaining scenarios
    wr(0, to_bcd(30)); wr(1, to_bcd(10)); wr(2, to_bcd(15)); wr(3, 8'h03);
    set_cur(30, 10, 15, 3);

    // R2 strobe at non-zero seconds never sets
    wr(4, 8'h01);
    for (int s = 1; s < 60; s++) begin
      tick(to_bcd(s)[6:0]);
      chk(alarm_flag, 1'b0, "R2 strobe at nonzero seconds");
    end
    // R2 seconds 00 without a strobe
    cur_sec = 7'h00;
    @(negedge clk);
    cur_sec = 7'h01;
    chk(alarm_flag, 1'b0, "R2 seconds 00 without strobe");

    // R7 sticky flag, write-1 has no effect
    tick(7'h00);
    chk(alarm_flag, 1'b1, "R7 flag set");
    set_cur(31, 10, 15, 3);
    wr(4, 8'h03);
    chk(alarm_flag, 1'b1, "R7 write 1 keeps flag");
    tick(7'h00);
    chk(alarm_flag, 1'b1, "R7 flag held across non-matching strobe");
    repeat (5) @(negedge clk);
    chk(alarm_flag, 1'b1, "R7 flag held while idle");
    wr(4, 8'h01);
    chk(alarm_flag, 1'b0, "R7 write 0 clears flag");
    wr(4, 8'h03);
    chk(alarm_flag, 1'b0, "R7 write 1 does not set flag");

    // R9 interrupt gating
    set_cur(30, 10, 15, 3);
    tick(7'h00);
    chk(irq_n, 1'b0, "R9 irq asserted");
    wr(4, 8'h02);
    chk(alarm_flag, 1'b1, "R9 flag kept when irq disabled");
    chk(irq_n, 1'b1, "R9 irq released by enable clear");
    wr(4, 8'h03);
    chk(irq_n, 1'b0, "R9 irq back with enable");
    wr(4, 8'h01);
    chk(irq_n, 1'b1, "R9 irq released by flag clear");

    // R8 clear and set in the same cycle
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
    sec_tick = 1'b1; cur_sec = 7'h00;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0; cur_sec = 7'h01;
    chk(alarm_flag, 1'b1, "R8 set wins over clear");
    chk(irq_n, 1'b0, "R8 irq with set flag");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule